// File: doc/BRIEF.md
# Privileged Control Register Bank

This block holds a set of privileged control registers behind a single indexed access port. Each access is one cycle of `acc_en_i` carrying a direction (`acc_wr_i`), an index and, for writes, data. Each index has its own rule. Some registers store the whole word. Some keep only certain bits. Some are cleared by any write. One may be set only once. Some can only be read or only be written, and a few act as command strobes for an external address-translation cache. Read data and the fault flag appear one cycle after the access.

A cycle counter runs from reset. Reading the cycle register returns the stored upper half joined with the live low half of that counter. While `spec_i` is high, writes are dropped silently: no state change, no fault and no strobe.

Top module: `priv_ctl_bank`

## Requirements
- R1: After reset every stored register reads zero, and `fault_o` and all four strobes are low.
- R2: Indices 0 to 3 are scratch registers that store and return the full 64-bit write data.
- R3: Masked stores keep only these bits of the write: index 4 (exception return address) clears bit 1 and keeps the rest; index 5 and index 6 keep 0xF; index 7 (priority level) keeps 0x1F; index 8 (mode) keeps 0x18; index 9 (software request) keeps 0x7FFF0; index 14 (address-space tag) keeps 0xFF.
- R4: A write of any data to index 10 or index 11 clears that register to zero.
- R5: Index 12 stores a full write. A read of it returns the stored bits 63:32 above bits 31:0 of the free-running cycle counter, which advances by one each clock.
- R6: Index 13 is set to 1 by its first write, whatever the data. A later write faults and leaves it at 1.
- R7: Indices 16 and 17 are read-only and return the inputs `hw_id_i` and `mm_stat_i`. A write to either faults.
- R8: Indices 20 to 24 are write-only. A read of any of them faults and returns zero.
- R9: Any index not named in R2 to R8 faults on both read and write, and a read of it returns zero.
- R10: A write to index 21 pulses `flush_all_o` for one cycle, and a write to index 22 pulses `flush_proc_o` for one cycle. At most one strobe is high in any cycle.
- R11: A write to index 23 pulses `flush_one_o`, and a write to index 24 pulses `insert_o`. With either pulse, `tb_addr_o` carries the write data and `tb_asn_o` carries bits 7:0 of index 14.
- R12: A write while `spec_i` is high changes no register, raises no fault and pulses no strobe.
- R13: `rdata_o`, `fault_o` and the strobes are registered and change on the clock edge that samples the access. `rdata_o` changes only on reads, and `fault_o` is high only in the cycle after a faulting access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| acc_en_i | input | 1 | Access valid this cycle |
| acc_wr_i | input | 1 | 1 = write, 0 = read |
| acc_idx_i | input | 5 | Register index |
| wdata_i | input | 64 | Write data |
| spec_i | input | 1 | Speculative: suppress writes |
| hw_id_i | input | 64 | Value returned by read-only index 16 |
| mm_stat_i | input | 64 | Value returned by read-only index 17 |
| rdata_o | output | 64 | Registered read data |
| fault_o | output | 1 | Registered access fault |
| flush_all_o | output | 1 | Invalidate-everything strobe |
| flush_proc_o | output | 1 | Invalidate-per-process strobe |
| flush_one_o | output | 1 | Invalidate-one-address strobe |
| insert_o | output | 1 | Insert-entry strobe |
| tb_addr_o | output | 64 | Address or tag sent with flush_one/insert |
| tb_asn_o | output | 8 | Address-space tag sent with flush_one/insert |

## Verification
The hardest case to reach is the live cycle merge, because the absolute counter value depends on how long the run has gone since reset. The stimulus reads index 12 twice with a known number of idle clocks between the reads and checks the difference of the low halves. It also checks that the upper half is the stored value. The once-only register needs two writes in sequence, and the second is the one that must fault. Speculative suppression is checked by writing a scratch register and a strobe index under `spec_i`, then reading the scratch value back and watching the strobes stay low.

// File: rtl/priv_ctl_bank.sv
module priv_ctl_bank #(
  parameter int DW = 64,
  parameter int IW = 5,
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_en_i,
  input  logic          acc_wr_i,
  input  logic [IW-1:0] acc_idx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          spec_i,
  input  logic [DW-1:0] hw_id_i,
  input  logic [DW-1:0] mm_stat_i,
  output logic [DW-1:0] rdata_o,
  output logic          fault_o,
  output logic          flush_all_o,
  output logic          flush_proc_o,
  output logic          flush_one_o,
  output logic          insert_o,
  output logic [DW-1:0] tb_addr_o,
  output logic [AW-1:0] tb_asn_o
);
  localparam int HALF  = DW / 2;
  localparam int NSTOR = 16;
  localparam int I_CYC = 12, I_ONCE = 13, I_ASN = 14, I_HWID = 16;
  localparam int I_FALL = 21, I_FPROC = 22, I_FONE = 23, I_INS = 24;

  typedef enum logic [2:0] {K_NONE, K_MASK, K_CLR, K_ONCE, K_RO, K_WO} kind_t;

  logic [DW-1:0]   regs [NSTOR];
  logic [HALF-1:0] cyc_q;
  kind_t           kind;
  logic [DW-1:0]   mask;
  logic [DW-1:0]   rd_val;
  logic            wr_fault, rd_fault, wr_ok;

  always_comb begin
    kind = K_NONE;
    mask = '1;
    case (int'(acc_idx_i))
      0, 1, 2, 3, 12: kind = K_MASK;
      4:       begin kind = K_MASK; mask = ~DW'(2);         end
      5, 6:    begin kind = K_MASK; mask = DW'(64'hF);      end
      7:       begin kind = K_MASK; mask = DW'(64'h1F);     end
      8:       begin kind = K_MASK; mask = DW'(64'h18);     end
      9:       begin kind = K_MASK; mask = DW'(64'h7FFF0);  end
      14:      begin kind = K_MASK; mask = DW'(64'hFF);     end
      10, 11:  kind = K_CLR;
      13:      kind = K_ONCE;
      16, 17:  kind = K_RO;
      20, 21, 22, 23, 24: kind = K_WO;
      default: kind = K_NONE;
    endcase
  end

  assign wr_fault = (kind == K_NONE) || (kind == K_RO) ||
                    ((kind == K_ONCE) && (regs[I_ONCE] != '0));
  assign rd_fault = (kind == K_NONE) || (kind == K_WO);
  assign wr_ok    = acc_en_i && acc_wr_i && !spec_i && !wr_fault;

  always_comb begin
    if (rd_fault)                      rd_val = '0;
    else if (kind == K_RO)             rd_val = (int'(acc_idx_i) == I_HWID) ? hw_id_i : mm_stat_i;
    else if (int'(acc_idx_i) == I_CYC) rd_val = {regs[I_CYC][DW-1:HALF], cyc_q};
    else                               rd_val = regs[acc_idx_i[3:0]];
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int i = 0; i < NSTOR; i++) regs[i] <= '0;
      cyc_q <= '0;
      rdata_o <= '0;
      fault_o <= 1'b0;
      flush_all_o <= 1'b0;
      flush_proc_o <= 1'b0;
      flush_one_o <= 1'b0;
      insert_o <= 1'b0;
      tb_addr_o <= '0;
      tb_asn_o <= '0;
    end else begin
      cyc_q <= cyc_q + 1'b1;
      fault_o <= acc_en_i && (acc_wr_i ? (!spec_i && wr_fault) : rd_fault);
      if (acc_en_i && !acc_wr_i) rdata_o <= rd_val;
      if (wr_ok) begin
        case (kind)
          K_MASK:  regs[acc_idx_i[3:0]] <= wdata_i & mask;
          K_CLR:   regs[acc_idx_i[3:0]] <= '0;
          K_ONCE:  regs[acc_idx_i[3:0]] <= DW'(1);
          default: ;
        endcase
      end
      flush_all_o  <= wr_ok && (int'(acc_idx_i) == I_FALL);
      flush_proc_o <= wr_ok && (int'(acc_idx_i) == I_FPROC);
      flush_one_o  <= wr_ok && (int'(acc_idx_i) == I_FONE);
      insert_o     <= wr_ok && (int'(acc_idx_i) == I_INS);
      if (wr_ok && (int'(acc_idx_i) == I_FONE || int'(acc_idx_i) == I_INS)) begin
        tb_addr_o <= wdata_i;
        tb_asn_o  <= regs[I_ASN][AW-1:0];
      end
    end
  end
endmodule

// File: rtl/priv_ctl_bank_chk.sv
module priv_ctl_bank_chk #(
  parameter int DW = 64,
  parameter int IW = 5,
  parameter int AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          acc_en_i,
  input logic          acc_wr_i,
  input logic [IW-1:0] acc_idx_i,
  input logic          spec_i,
  input logic [DW-1:0] rdata_o,
  input logic          fault_o,
  input logic          flush_all_o,
  input logic          flush_proc_o,
  input logic          flush_one_o,
  input logic          insert_o
);
  // R13
  fault_needs_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(acc_en_i));

  // R12
  spec_write_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en_i && acc_wr_i && spec_i) |=>
      !fault_o && !flush_all_o && !flush_proc_o && !flush_one_o && !insert_o);

  // R10
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({flush_all_o, flush_proc_o, flush_one_o, insert_o}));

  // R9
  fault_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en_i && !acc_wr_i) |=> (!fault_o || rdata_o == '0));

  // R10
  flush_all_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_o |-> $past(acc_en_i && acc_wr_i && !spec_i && int'(acc_idx_i) == 21));

  // R11
  insert_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insert_o |-> $past(acc_en_i && acc_wr_i && !spec_i && int'(acc_idx_i) == 24));
endmodule

bind priv_ctl_bank priv_ctl_bank_chk #(.DW(DW), .IW(IW), .AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .acc_en_i(acc_en_i), .acc_wr_i(acc_wr_i),
  .acc_idx_i(acc_idx_i), .spec_i(spec_i), .rdata_o(rdata_o), .fault_o(fault_o),
  .flush_all_o(flush_all_o), .flush_proc_o(flush_proc_o),
  .flush_one_o(flush_one_o), .insert_o(insert_o));

// File: tb/test_priv_ctl_bank.sv
module test_priv_ctl_bank;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] HWID = 64'h0000_00C0_FFEE_0042;
  localparam logic [63:0] MMST = 64'h0000_0000_0000_1357;

  logic clk = 0, rst_n = 0;
  logic en = 0, wr = 0, spec = 0;
  logic [4:0] idx = '0;
  logic [63:0] wd = '0;
  logic [63:0] rdata, addr;
  logic fault, fa, fp, fo, ins;
  logic [7:0] asn;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  priv_ctl_bank i_priv_ctl_bank (
    .clk_i(clk), .rst_ni(rst_n), .acc_en_i(en), .acc_wr_i(wr), .acc_idx_i(idx),
    .wdata_i(wd), .spec_i(spec), .hw_id_i(HWID), .mm_stat_i(MMST),
    .rdata_o(rdata), .fault_o(fault), .flush_all_o(fa), .flush_proc_o(fp),
    .flush_one_o(fo), .insert_o(ins), .tb_addr_o(addr), .tb_asn_o(asn));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(input bit w, input int i, input logic [63:0] d);
    @(negedge clk);
    en = 1; wr = w; idx = 5'(i); wd = d;
    @(posedge clk); #1;
    en = 0; wr = 0;
  endtask

  task automatic rd_chk(input int i, input logic [63:0] exp, input string req);
    acc(0, i, '0);
    check(rdata == exp && !fault, req, rdata, exp);
  endtask

  task automatic t_reset;
    check(!fault && !fa && !fp && !fo && !ins, "R1", {59'd0, fault, fa, fp, fo, ins}, 0);
    rd_chk(2, 0, "R1");
    rd_chk(9, 0, "R1");
  endtask

  task automatic t_plain;
    acc(1, 0, 64'hDEAD_BEEF_0123_4567); check(!fault, "R2", fault, 0);
    acc(1, 3, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_chk(0, 64'hDEAD_BEEF_0123_4567, "R2");
    rd_chk(3, 64'hFFFF_FFFF_FFFF_FFFF, "R2");
  endtask

  task automatic t_masks;
    acc(1, 4, '1);  rd_chk(4, 64'hFFFF_FFFF_FFFF_FFFD, "R3");
    acc(1, 5, '1);  rd_chk(5, 64'hF, "R3");
    acc(1, 6, 64'h33); rd_chk(6, 64'h3, "R3");
    acc(1, 7, '1);  rd_chk(7, 64'h1F, "R3");
    acc(1, 8, '1);  rd_chk(8, 64'h18, "R3");
    acc(1, 9, '1);  rd_chk(9, 64'h7FFF0, "R3");
    acc(1, 14, 64'h1A5); rd_chk(14, 64'hA5, "R3");
  endtask

  task automatic t_clear;
    acc(1, 10, 64'h1234); check(!fault, "R4", fault, 0);
    rd_chk(10, 0, "R4");
    acc(1, 11, '1);
    rd_chk(11, 0, "R4");
  endtask

  task automatic t_cycle;
    logic [63:0] a, b;
    acc(1, 12, 64'hABCD_0000_1234_5678);
    acc(0, 12, '0); a = rdata;
    check(a[63:32] == 32'hABCD_0000 && !fault, "R5", a, 64'hABCD_0000_0000_0000);
    repeat (5) @(posedge clk);
    acc(0, 12, '0); b = rdata;
    check(b[31:0] - a[31:0] == 32'd6, "R5", 64'(b[31:0] - a[31:0]), 64'd6);
  endtask

  task automatic t_once;
    acc(1, 13, 64'h55); check(!fault, "R6", fault, 0);
    rd_chk(13, 1, "R6");
    acc(1, 13, 64'h0); check(fault, "R6", fault, 1);
    rd_chk(13, 1, "R6");
  endtask

  task automatic t_ro;
    acc(1, 16, 64'h99); check(fault, "R7", fault, 1);
    rd_chk(16, HWID, "R7");
    acc(1, 17, 64'h99); check(fault, "R7", fault, 1);
    rd_chk(17, MMST, "R7");
  endtask

  task automatic t_wo;
    rd_chk(0, 64'hDEAD_BEEF_0123_4567, "R8");
    acc(0, 23, '0);
    check(fault && rdata == 0, "R8", rdata, 0);
    acc(0, 20, '0);
    check(fault, "R8", fault, 1);
  endtask

  task automatic t_unknown;
    rd_chk(3, 64'hFFFF_FFFF_FFFF_FFFF, "R9");
    acc(0, 31, '0);
    check(fault && rdata == 0, "R9", rdata, 0);
    acc(1, 15, 64'h7);
    check(fault, "R9", fault, 1);
  endtask

  task automatic t_flush;
    acc(1, 21, 64'h77);
    check(fa && !fp && !fo && !ins && !fault, "R10", {60'd0, fa, fp, fo, ins}, 64'h8);
    @(posedge clk); #1;
    check(!fa, "R10", fa, 0);
    acc(1, 22, 64'h77);
    check(fp && !fa && !fo && !ins, "R10", {60'd0, fa, fp, fo, ins}, 64'h4);
    acc(1, 23, 64'h0000_1000_2000_3000);
    check(fo && addr == 64'h0000_1000_2000_3000 && asn == 8'hA5, "R11", addr, 64'h0000_1000_2000_3000);
    check(!fp, "R10", fp, 0);
    acc(1, 24, 64'h0000_0000_0BAD_F00D);
    check(ins && !fo && addr == 64'h0BAD_F00D && asn == 8'hA5, "R11", {48'd0, asn, 7'd0, ins}, {48'd0, 8'hA5, 8'd1});
  endtask

  task automatic t_spec;
    spec = 1;
    acc(1, 0, 64'h1111);
    check(!fault, "R12", fault, 0);
    acc(1, 21, '0);
    check(!fa && !fault, "R12", fa, 0);
    acc(1, 15, '0);
    check(!fault, "R12", fault, 0);
    spec = 0;
    rd_chk(0, 64'hDEAD_BEEF_0123_4567, "R12");
  endtask

  task automatic t_timing;
    acc(0, 7, '0);
    @(negedge clk); en = 1; wr = 0; idx = 5'd8;
    #1; check(rdata == 64'h1F, "R13", rdata, 64'h1F);
    @(posedge clk); #1; en = 0;
    check(rdata == 64'h18, "R13", rdata, 64'h18);
    acc(1, 2, 64'h5);
    check(rdata == 64'h18, "R13", rdata, 64'h18);
    acc(1, 31, '0);
    @(posedge clk); #1;
    check(!fault, "R13", fault, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_plain();
    t_masks();
    t_clear();
    t_cycle();
    t_once();
    t_ro();
    t_wo();
    t_unknown();
    t_flush();
    t_spec();
    t_timing();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule